// File: doc/BRIEF.md
# Character Display Command Decoder

This block is the command front end of a character display controller for a panel of four lines by twelve columns. Every write carries a register-select bit and an 8-bit byte. With the select bit low, the byte is a command, decoded by its highest set bit. With the select bit high, the byte is data for one of three memories, and the block keeps a single 7-bit address counter pointing into them: the display character RAM, the glyph RAM and the icon RAM.

The block holds the mode state that a display pipeline downstream needs:
- entry direction and auto-shift;
- display, cursor and blink enables;
- power-down;
- a 4-bit contrast code;
- a common horizontal start offset, published as a start address for each line.

The block drives a write port toward the memories. During a clear it sweeps the blank code through every display location by itself. Busy is held for a command-specific number of clock ticks, and writes that arrive while busy are dropped and flagged.

Top module: `chr_cmd_decoder`

## Requirements
- R1: After reset the state is: address counter 0, offset 0, display, cursor and blink off, increment mode on, auto-shift off, power-down off, contrast 0, error flag clear. Busy is then high for CLR_TICKS cycles while a clear sweep writes the blank code to all 48 display locations.
- R2: With `rs`=0, a byte is decoded by its highest set bit. The codes are: 0x01 clear, 0x02-0x03 home, 0x04-0x07 entry mode (bit1 increment, bit0 auto-shift), 0x08-0x0F display control (bit2 display, bit1 cursor, bit0 blink), 0x10-0x1F shift, 0x20-0x3F function (bit0 power on), 0x40-0x7F contrast, 0x80-0xFF address set. The byte 0x00 changes nothing.
- R3: Address set loads byte bits 6..0 into the counter. A data write goes to the region the counter selects, and `ram_sel` reports it as 0 display, 1 glyph or 2 icon. Display occupies 0xL0-0xLB for line L of 0..3, glyph 0x40-0x5F and icon 0x60-0x7F. Display writes carry all 8 bits. Glyph and icon writes carry bits 4..0 with bits 7..5 zero. Addresses 0xLC-0xLF are not written.
- R4: After a data write the counter steps by +1 when increment mode is on and by -1 otherwise. Inside display space it wraps between lines: 0x0B+1=0x10, 0x3B+1=0x00, 0x10-1=0x0B, 0x00-1=0x3B. Elsewhere it steps modulo 128.
- R5: The display offset stays in 0..11. A left shift adds 1 modulo 12 and a right shift subtracts 1 modulo 12. Line L starts at address 16*L plus the offset. A display shift comes from 0x18 (left) or 0x1C (right), or from a display-region data write with auto-shift on (left when incrementing, right when decrementing). A display shift leaves the counter unchanged.
- R6: Command 0x10 moves the counter one step down and 0x14 one step up, with the same wrapping as R4.
- R7: Return home sets the counter and the offset to 0.
- R8: Clear sets the counter and offset to 0 and forces increment mode on, leaving auto-shift unchanged. It writes 0x20 to each of the 48 display locations, one per cycle, inside its busy window.
- R9: Function set with bit0=0 sets power-down and turns the display off. Function set with bit0=1 clears power-down and leaves the display off.
- R10: The contrast command loads byte bits 3..0 into `contrast`.
- R11: After an accepted write, busy is high for CLR_TICKS cycles for clear, and for LONG_TICKS cycles for home, shift, address set and data writes. It is not raised for any other command.
- R12: A write strobed while busy changes no state and produces no RAM write. It sets the error flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rs | input | 1 | 0 command, 1 data |
| wr_stb | input | 1 | Write strobe, one byte per high cycle |
| din | input | 8 | Command or data byte |
| ram_we | output | 1 | RAM write enable |
| ram_sel | output | 2 | Target memory: 0 display, 1 glyph, 2 icon |
| ram_addr | output | 7 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| addr_cnt | output | 7 | Address counter |
| disp_ofs | output | 4 | Common line start offset |
| line_start | output | 28 | Start address per line, line L in bits 7L+6..7L |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| inc_mode | output | 1 | 1 increment, 0 decrement |
| shift_mode | output | 1 | Auto-shift on display writes |
| pwr_down | output | 1 | Power-down active |
| contrast | output | 4 | Contrast code |
| busy | output | 1 | Command in progress |
| err | output | 1 | Sticky write-while-busy flag |

## Verification
The bench goes after the line-end wrap in both directions. A counter that simply adds one would land on 0x0C or 0x3C and send characters into invisible cells. It also checks the offset wrap at both ends of 0..11, where a plain 4-bit counter would reach 12 or 15 and skew every line. Further checks cover the clear sweep and mode handling: a clear that rewrote the wrong cells or the wrong count, or that altered auto-shift, is caught by counting its writes and reading the modes back. Writes into the unused cells of a line, the narrowed glyph and icon data, power-down forcing the display off, and a strobe inside the busy window are each checked as well; a design that let the busy-window strobe through would move the counter or write memory.

// File: rtl/chr_cmd_pkg.sv
package chr_cmd_pkg;
  localparam int unsigned COLS  = 12;
  localparam int unsigned LINES = 4;
  localparam int unsigned AW    = 7;
  localparam int unsigned DW    = 8;
  localparam int unsigned NARROW = 5;
  localparam logic [DW-1:0] BLANK = 8'h20;

  typedef enum logic [1:0] {
    RG_DISP  = 2'd0,
    RG_GLYPH = 2'd1,
    RG_ICON  = 2'd2,
    RG_GAP   = 2'd3
  } region_e;

  typedef enum logic [3:0] {
    CM_NOP, CM_CLEAR, CM_HOME, CM_ENTRY, CM_DCTL,
    CM_SHIFT, CM_FUNC, CM_CONTRAST, CM_ADDR
  } cmd_e;

  // Command class from the position of the highest set bit.
  function automatic cmd_e decode_cmd(input logic [DW-1:0] b);
    casez (b)
      8'b1???????: return CM_ADDR;
      8'b01??????: return CM_CONTRAST;
      8'b001?????: return CM_FUNC;
      8'b0001????: return CM_SHIFT;
      8'b00001???: return CM_DCTL;
      8'b000001??: return CM_ENTRY;
      8'b0000001?: return CM_HOME;
      8'b00000001: return CM_CLEAR;
      default:     return CM_NOP;
    endcase
  endfunction

  function automatic region_e addr_region(input logic [AW-1:0] a);
    if (a[6]) return a[5] ? RG_ICON : RG_GLYPH;
    if (a[3:0] < 4'(COLS)) return RG_DISP;
    return RG_GAP;
  endfunction

  // One counter step; display space wraps from line end to next line.
  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic up);
    if (addr_region(a) == RG_DISP) begin
      if (up) return (a[3:0] == 4'(COLS-1)) ? {1'b0, a[5:4] + 2'd1, 4'd0} : a + 7'd1;
      return (a[3:0] == 4'd0) ? {1'b0, a[5:4] - 2'd1, 4'(COLS-1)} : a - 7'd1;
    end
    return up ? a + 7'd1 : a - 7'd1;
  endfunction

  // Rotate the start offset inside one line.
  function automatic logic [3:0] rot_ofs(input logic [3:0] o, input logic left);
    if (left) return (o == 4'(COLS-1)) ? 4'd0 : o + 4'd1;
    return (o == 4'd0) ? 4'(COLS-1) : o - 4'd1;
  endfunction
endpackage

// File: rtl/chr_busy_timer.sv
module chr_busy_timer #(
  parameter int unsigned CW        = 10,
  parameter int unsigned RST_TICKS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= CW'(RST_TICKS);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  a_r11_load_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> busy);
endmodule

// File: rtl/chr_clear_sweep.sv
module chr_clear_sweep
  import chr_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          active,
  output logic [AW-1:0] addr
);
  logic [1:0] line;
  logic [3:0] col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b1;
      line   <= '0;
      col    <= '0;
    end else if (start) begin
      active <= 1'b1;
      line   <= '0;
      col    <= '0;
    end else if (active) begin
      if (col == 4'(COLS-1)) begin
        col <= '0;
        if (line == 2'(LINES-1)) active <= 1'b0;
        else                     line   <= line + 2'd1;
      end else begin
        col <= col + 4'd1;
      end
    end
  end

  assign addr = {1'b0, line, col};
endmodule

// File: rtl/chr_shift_offset.sv
module chr_shift_offset
  import chr_cmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                home,
  input  logic                step,
  input  logic                left,
  output logic [3:0]          ofs,
  output logic [LINES*AW-1:0] line_start
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ofs <= '0;
    else if (home)  ofs <= '0;
    else if (step)  ofs <= rot_ofs(ofs, left);
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign line_start[g*AW +: AW] = AW'(g*16) + AW'(ofs);
  end

  a_r5_ofs_range: assert property (@(posedge clk) disable iff (!rst_n)
    ofs < 4'(COLS));
  a_r7_home_zero: assert property (@(posedge clk) disable iff (!rst_n)
    home |=> (ofs == 4'd0));
endmodule

// File: rtl/chr_cmd_decoder.sv
module chr_cmd_decoder
  import chr_cmd_pkg::*;
#(
  parameter int unsigned CLR_TICKS  = 976,
  parameter int unsigned LONG_TICKS = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rs,
  input  logic                wr_stb,
  input  logic [DW-1:0]       din,
  output logic                ram_we,
  output logic [1:0]          ram_sel,
  output logic [AW-1:0]       ram_addr,
  output logic [DW-1:0]       ram_wdata,
  output logic [AW-1:0]       addr_cnt,
  output logic [3:0]          disp_ofs,
  output logic [LINES*AW-1:0] line_start,
  output logic                disp_on,
  output logic                cursor_on,
  output logic                blink_on,
  output logic                inc_mode,
  output logic                shift_mode,
  output logic                pwr_down,
  output logic [3:0]          contrast,
  output logic                busy,
  output logic                err
);
  localparam int unsigned CW = $clog2(CLR_TICKS + 1);

  initial begin
    a_cfg_ticks: assert (CLR_TICKS >= COLS*LINES && CLR_TICKS >= LONG_TICKS);
  end

  // Named events for the assertions and the submodules.
  logic    acc_cmd, acc_data, do_clear, do_home, do_dshift, shift_left;
  logic    busy_load, swp_act;
  logic [CW-1:0] busy_val;
  logic [AW-1:0] swp_addr;
  cmd_e    cmd;
  region_e cur_rgn;

  assign cmd      = decode_cmd(din);
  assign cur_rgn  = addr_region(addr_cnt);
  assign acc_cmd  = wr_stb && !busy && !rs;
  assign acc_data = wr_stb && !busy && rs;
  assign do_clear = acc_cmd && (cmd == CM_CLEAR);
  assign do_home  = do_clear || (acc_cmd && cmd == CM_HOME);
  assign do_dshift = (acc_cmd && cmd == CM_SHIFT && din[3]) ||
                     (acc_data && shift_mode && cur_rgn == RG_DISP);
  assign shift_left = acc_data ? inc_mode : !din[2];

  always_comb begin
    busy_load = 1'b0;
    busy_val  = '0;
    if (acc_data) begin
      busy_load = 1'b1;
      busy_val  = CW'(LONG_TICKS);
    end else if (acc_cmd) begin
      case (cmd)
        CM_CLEAR: begin busy_load = 1'b1; busy_val = CW'(CLR_TICKS); end
        CM_HOME, CM_SHIFT, CM_ADDR: begin busy_load = 1'b1; busy_val = CW'(LONG_TICKS); end
        default: ;
      endcase
    end
  end

  chr_busy_timer #(.CW(CW), .RST_TICKS(CLR_TICKS)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(busy_load), .load_val(busy_val), .busy(busy)
  );

  chr_clear_sweep u_sweep (
    .clk(clk), .rst_n(rst_n), .start(do_clear), .active(swp_act), .addr(swp_addr)
  );

  chr_shift_offset u_ofs (
    .clk(clk), .rst_n(rst_n), .home(do_home), .step(do_dshift), .left(shift_left),
    .ofs(disp_ofs), .line_start(line_start)
  );

  // RAM write port: clear sweep or accepted data write.
  always_comb begin
    ram_we    = 1'b0;
    ram_sel   = 2'(RG_DISP);
    ram_addr  = addr_cnt;
    ram_wdata = din;
    if (swp_act) begin
      ram_we    = 1'b1;
      ram_addr  = swp_addr;
      ram_wdata = BLANK;
    end else if (acc_data && cur_rgn != RG_GAP) begin
      ram_we  = 1'b1;
      ram_sel = 2'(cur_rgn);
      if (cur_rgn != RG_DISP) ram_wdata = {{(DW-NARROW){1'b0}}, din[NARROW-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_cnt   <= '0;
      inc_mode   <= 1'b1;
      shift_mode <= 1'b0;
      disp_on    <= 1'b0;
      cursor_on  <= 1'b0;
      blink_on   <= 1'b0;
      pwr_down   <= 1'b0;
      contrast   <= '0;
      err        <= 1'b0;
    end else begin
      if (wr_stb && busy) err <= 1'b1;
      if (acc_data) begin
        addr_cnt <= step_addr(addr_cnt, inc_mode);
      end else if (acc_cmd) begin
        case (cmd)
          CM_CLEAR: begin addr_cnt <= '0; inc_mode <= 1'b1; end
          CM_HOME:  addr_cnt <= '0;
          CM_ENTRY: begin inc_mode <= din[1]; shift_mode <= din[0]; end
          CM_DCTL:  begin disp_on <= din[2]; cursor_on <= din[1]; blink_on <= din[0]; end
          CM_SHIFT: if (!din[3]) addr_cnt <= step_addr(addr_cnt, din[2]);
          CM_FUNC:  begin
            pwr_down <= !din[0];
            if (!din[0]) disp_on <= 1'b0;
          end
          CM_CONTRAST: contrast <= din[3:0];
          CM_ADDR:  addr_cnt <= din[AW-1:0];
          default: ;
        endcase
      end
    end
  end

  a_r12_hold_ac: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && busy) |=> $stable(addr_cnt));
  a_r12_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && busy) |=> err);
  a_r8_sweep_blank: assert property (@(posedge clk) disable iff (!rst_n)
    swp_act |-> (ram_we && ram_wdata == BLANK && ram_sel == 2'(RG_DISP) && ram_addr[3:0] < 4'(COLS)));
  a_r9_pd_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> !disp_on);
  a_r3_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_sel != 2'(RG_DISP)) |-> (ram_wdata[7:5] == 3'b000));
endmodule

// File: tb/test_chr_cmd_decoder.sv
module test_chr_cmd_decoder;
  localparam int CLK_PER = 10;
  localparam int TB_CLR  = 60;
  localparam int TB_LONG = 5;

  logic clk = 1'b0;
  logic rst_n, rs, wr_stb;
  logic [7:0] din;
  logic ram_we, disp_on, cursor_on, blink_on, inc_mode, shift_mode, pwr_down, busy, err;
  logic [1:0] ram_sel;
  logic [6:0] ram_addr, addr_cnt;
  logic [7:0] ram_wdata;
  logic [3:0] disp_ofs, contrast;
  logic [27:0] line_start;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  chr_cmd_decoder #(.CLR_TICKS(TB_CLR), .LONG_TICKS(TB_LONG)) i_chr_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .rs(rs), .wr_stb(wr_stb), .din(din),
    .ram_we(ram_we), .ram_sel(ram_sel), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .addr_cnt(addr_cnt), .disp_ofs(disp_ofs), .line_start(line_start),
    .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on), .inc_mode(inc_mode),
    .shift_mode(shift_mode), .pwr_down(pwr_down), .contrast(contrast), .busy(busy), .err(err)
  );

  // Vector: {req, rs, din, exp addr, exp offset, exp flags, exp contrast}
  // flags = {display, cursor, blink, increment, auto-shift, power-down}
  localparam int NV = 34;
  localparam logic [33:0] VEC [NV] = '{
    {4'd2,  1'b0, 8'h0F, 7'h00, 4'd0,  6'b111100, 4'h0}, // R2 display control
    {4'd3,  1'b0, 8'h8B, 7'h0B, 4'd0,  6'b111100, 4'h0}, // R3 address set
    {4'd4,  1'b1, 8'h41, 7'h10, 4'd0,  6'b111100, 4'h0}, // R4 line-end wrap up
    {4'd6,  1'b0, 8'h10, 7'h0B, 4'd0,  6'b111100, 4'h0}, // R6 cursor down across line
    {4'd6,  1'b0, 8'h14, 7'h10, 4'd0,  6'b111100, 4'h0}, // R6 cursor up
    {4'd5,  1'b0, 8'h18, 7'h10, 4'd1,  6'b111100, 4'h0}, // R5 display left
    {4'd5,  1'b0, 8'h1C, 7'h10, 4'd0,  6'b111100, 4'h0}, // R5 display right
    {4'd5,  1'b0, 8'h1C, 7'h10, 4'd11, 6'b111100, 4'h0}, // R5 offset wraps low
    {4'd2,  1'b0, 8'h07, 7'h10, 4'd11, 6'b111110, 4'h0}, // R2 entry inc+shift
    {4'd5,  1'b1, 8'h42, 7'h11, 4'd0,  6'b111110, 4'h0}, // R5 auto shift wraps high
    {4'd2,  1'b0, 8'h04, 7'h11, 4'd0,  6'b111000, 4'h0}, // R2 entry decrement
    {4'd3,  1'b0, 8'h80, 7'h00, 4'd0,  6'b111000, 4'h0}, // R3
    {4'd4,  1'b1, 8'h43, 7'h3B, 4'd0,  6'b111000, 4'h0}, // R4 wrap 0x00 down
    {4'd4,  1'b1, 8'h44, 7'h3A, 4'd0,  6'b111000, 4'h0}, // R4
    {4'd2,  1'b0, 8'h06, 7'h3A, 4'd0,  6'b111100, 4'h0}, // R2
    {4'd3,  1'b0, 8'hC0, 7'h40, 4'd0,  6'b111100, 4'h0}, // R3 glyph space
    {4'd3,  1'b1, 8'hFF, 7'h41, 4'd0,  6'b111100, 4'h0}, // R3 narrow glyph data
    {4'd3,  1'b0, 8'hFF, 7'h7F, 4'd0,  6'b111100, 4'h0}, // R3 icon space
    {4'd4,  1'b1, 8'hAA, 7'h00, 4'd0,  6'b111100, 4'h0}, // R4 modulo 128 wrap
    {4'd3,  1'b0, 8'hBB, 7'h3B, 4'd0,  6'b111100, 4'h0}, // R3
    {4'd4,  1'b1, 8'h45, 7'h00, 4'd0,  6'b111100, 4'h0}, // R4 wrap 0x3B up
    {4'd5,  1'b0, 8'h18, 7'h00, 4'd1,  6'b111100, 4'h0}, // R5
    {4'd7,  1'b0, 8'h03, 7'h00, 4'd0,  6'b111100, 4'h0}, // R7 home
    {4'd9,  1'b0, 8'h20, 7'h00, 4'd0,  6'b011101, 4'h0}, // R9 power down
    {4'd9,  1'b0, 8'h21, 7'h00, 4'd0,  6'b011100, 4'h0}, // R9 wake, display stays off
    {4'd10, 1'b0, 8'h4A, 7'h00, 4'd0,  6'b011100, 4'hA}, // R10
    {4'd10, 1'b0, 8'h7F, 7'h00, 4'd0,  6'b011100, 4'hF}, // R10
    {4'd2,  1'b0, 8'h00, 7'h00, 4'd0,  6'b011100, 4'hF}, // R2 no-op
    {4'd2,  1'b0, 8'h05, 7'h00, 4'd0,  6'b011010, 4'hF}, // R2 dec + shift
    {4'd3,  1'b0, 8'h8C, 7'h0C, 4'd0,  6'b011010, 4'hF}, // R3 gap cell
    {4'd3,  1'b1, 8'h55, 7'h0B, 4'd0,  6'b011010, 4'hF}, // R3 gap not written
    {4'd5,  1'b0, 8'h1B, 7'h0B, 4'd1,  6'b011010, 4'hF}, // R5 counter unchanged
    {4'd8,  1'b0, 8'h01, 7'h00, 4'd0,  6'b011110, 4'hF}, // R8 clear
    {4'd11, 1'b0, 8'h08, 7'h00, 4'd0,  6'b000110, 4'hF}  // R11 no busy
  };

  task automatic chk(input int req, input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Own restatement of the address map: 0 display, 1 glyph, 2 icon, 3 unused.
  function automatic int tb_region(input logic [6:0] a);
    if (a >= 7'h60) return 2;
    if (a >= 7'h40) return 1;
    if ((a % 16) < 12) return 0;
    return 3;
  endfunction

  function automatic int tb_busy(input logic r, input logic [7:0] d);
    if (r) return TB_LONG;
    if (d == 8'h01) return TB_CLR;
    if (d >= 8'h80 || (d >= 8'h10 && d < 8'h20) || d == 8'h02 || d == 8'h03) return TB_LONG;
    return 0;
  endfunction

  task automatic issue(input logic r, input logic [7:0] d, output int nbusy, output int nwe,
                       output logic we0, output logic [1:0] sel0, output logic [6:0] a0,
                       output logic [7:0] w0);
    @(negedge clk);
    rs = r; din = d; wr_stb = 1'b1;
    #1;
    we0 = ram_we; sel0 = ram_sel; a0 = ram_addr; w0 = ram_wdata;
    @(negedge clk);
    wr_stb = 1'b0;
    nbusy = 0; nwe = 0;
    while (busy && nbusy < 5000) begin
      nbusy++;
      if (ram_we) nwe++;
      @(negedge clk);
    end
  endtask

  task automatic check_lines(input int req, input logic [3:0] o);
    for (int l = 0; l < 4; l++)
      chk(req, line_start[l*7 +: 7] == 7'(16*l + o), "line start", line_start[l*7 +: 7], 7'(16*l + o));
  endtask

  initial begin
    logic [6:0] prev_ac;
    int nb, nw;
    logic we0;
    logic [1:0] sel0;
    logic [6:0] a0;
    logic [7:0] w0;

    rst_n = 1'b0; rs = 1'b0; wr_stb = 1'b0; din = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(1, addr_cnt == 7'h00, "reset addr", addr_cnt, 0);
    chk(1, {disp_on, cursor_on, blink_on, inc_mode, shift_mode, pwr_down} == 6'b000100,
        "reset flags", {disp_on, cursor_on, blink_on, inc_mode, shift_mode, pwr_down}, 6'b000100);
    chk(1, contrast == 4'h0 && err == 1'b0 && disp_ofs == 4'd0, "reset contrast/err/offset",
        {contrast, err, disp_ofs}, 0);
    check_lines(1, 4'd0);
    nb = 0; nw = 0;
    while (busy && nb < 5000) begin
      nb++;
      if (ram_we && ram_wdata == 8'h20) nw++;
      @(negedge clk);
      #1;
    end
    chk(1, nb == TB_CLR, "reset busy length", nb, TB_CLR);
    chk(1, nw == 48, "reset blank writes", nw, 48);

    prev_ac = 7'h00;
    for (int i = 0; i < NV; i++) begin
      automatic int req = int'(VEC[i][33:30]);
      automatic logic r = VEC[i][29];
      automatic logic [7:0] d = VEC[i][28:21];
      automatic logic [6:0] eac = VEC[i][20:14];
      automatic logic [3:0] eofs = VEC[i][13:10];
      automatic logic [5:0] efl = VEC[i][9:4];
      automatic logic [3:0] econ = VEC[i][3:0];
      automatic int rg = tb_region(prev_ac);
      issue(r, d, nb, nw, we0, sel0, a0, w0);
      if (r) begin
        // R3 write port
        if (rg == 3)
          chk(req, we0 == 1'b0, "unused cell write", we0, 0);
        else
          chk(req, we0 && sel0 == 2'(rg) && a0 == prev_ac &&
                   w0 == ((rg == 0) ? d : {3'b000, d[4:0]}),
              "ram port", {we0, sel0, a0, w0},
              {1'b1, 2'(rg), prev_ac, ((rg == 0) ? d : {3'b000, d[4:0]})});
      end
      // R11 busy durations
      chk(11, nb == tb_busy(r, d), "busy length", nb, tb_busy(r, d));
      chk(8, nw == ((!r && d == 8'h01) ? 48 : 0), "sweep writes", nw, (!r && d == 8'h01) ? 48 : 0);
      chk(req, addr_cnt == eac, "addr counter", addr_cnt, eac);
      chk(req, disp_ofs == eofs, "offset", disp_ofs, eofs);
      chk(req, {disp_on, cursor_on, blink_on, inc_mode, shift_mode, pwr_down} == efl, "flags",
          {disp_on, cursor_on, blink_on, inc_mode, shift_mode, pwr_down}, efl);
      chk(req, contrast == econ, "contrast", contrast, econ);
      prev_ac = eac;
    end
    check_lines(5, 4'd0);

    // R5 per-line start with non-zero offset
    issue(1'b0, 8'h1C, nb, nw, we0, sel0, a0, w0);
    check_lines(5, 4'd11);

    // R12 writes inside the busy window are dropped
    @(negedge clk);
    rs = 1'b0; din = 8'h85; wr_stb = 1'b1;
    @(negedge clk);
    din = 8'h8A;
    @(negedge clk);
    rs = 1'b1; din = 8'h99;
    #1;
    chk(12, ram_we == 1'b0, "write while busy", ram_we, 0);
    @(negedge clk);
    wr_stb = 1'b0;
    nb = 0;
    while (busy && nb < 5000) begin nb++; @(negedge clk); end
    chk(12, addr_cnt == 7'h05, "addr after dropped writes", addr_cnt, 7'h05);
    chk(12, err == 1'b1, "error flag set", err, 1);
    issue(1'b0, 8'h80, nb, nw, we0, sel0, a0, w0);
    chk(12, err == 1'b1, "error flag sticky", err, 1);

    // R1 reset clears the flag
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(1, err == 1'b0 && addr_cnt == 7'h00 && disp_ofs == 4'd0, "second reset",
        {err, addr_cnt, disp_ofs}, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule